// File: doc/BRIEF.md
# Byte-Lane Asynchronous SRAM Model

This block is a synthesizable behavioural stand-in for a 32-bit-wide asynchronous static RAM. It lets an FPGA-hosted testbench drive a memory controller against a realistic target. An internal clock, much faster than the controlled interface, samples the control and address inputs. The block decodes the device mode from three active-low selects, a write strobe, an output strobe and four active-low byte-lane strobes. It stores writes one byte lane at a time.

The bidirectional data bus is split into three parts: an input vector, a read-data vector, and one drive-enable bit per byte lane. The enclosing logic or pad wrapper builds the tri-state. A write is committed on the sampling edge where the write condition is first seen to be false, which matches a write that ends on its terminating edge. Until that edge, a read of the same word is forwarded from the captured write. The port keeps the full 19-bit address. A parameter shrinks the stored depth so that the array fits in on-chip memory.

Top module: `lane_sram_model`

## Requirements
- R1: The device is selected only when all three bits of `cs_n_i` are 0. While any of them is 1, `drive_o` is 0000, `rdata_o` is zero and no write is captured.
- R2: The write condition is: device selected and `we_n_i` = 0. While it holds, `drive_o` is 0000 whatever the value of `oe_n_i`.
- R3: Bit k of `lane_n_i` governs data bits 8k+7 down to 8k, for both reads and writes. Bit 0 governs the least significant byte.
- R4: A write is stored on the first rising `clk_i` edge that samples the write condition false after an edge that sampled it true. The address, data and lane enables stored are those sampled at the last edge where the condition held.
- R5: During a write, byte lanes whose `lane_n_i` bit is 1 keep their previous contents at the addressed word.
- R6: When the device is selected with `we_n_i` = 1 and `oe_n_i` = 0, `drive_o[k]` = NOT `lane_n_i[k]`. Each driven lane shows the stored byte. Every undriven lane reads as zero.
- R7: When the device is selected with `oe_n_i` = 1, or with all four `lane_n_i` bits at 1, `drive_o` is 0000.
- R8: Only the low DEPTH_LOG2 address bits (10 by default) select a word. Higher address bits are ignored, so addresses 0x00005 and 0x00405 name the same word.
- R9: In the cycle after the write condition drops, before the storing edge, a read of the same word returns the newly written lanes combined with the old contents of the other lanes.
- R10: While `rst_ni` is low, any pending write is discarded. A write whose terminating sample falls during reset never reaches the array.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast sampling clock |
| rst_ni | input | 1 | Active-low asynchronous reset of the write tracker |
| addr_i | input | 19 | Word address |
| cs_n_i | input | 3 | Active-low chip selects, all must be low |
| we_n_i | input | 1 | Active-low write strobe |
| oe_n_i | input | 1 | Active-low output strobe |
| lane_n_i | input | 4 | Active-low byte-lane strobes |
| wdata_i | input | 32 | Data bus as seen entering the device |
| rdata_o | output | 32 | Read data, zero on undriven lanes |
| drive_o | output | 4 | Per-lane bus drive enable |

## Verification
A wrong capture register or lane mask shows as corrupted bytes on the first read after the write completes. Such a read takes three sampling cycles after the write begins. A stale mask shows up either in lanes that should have kept old data or in lanes that missed new data. A broken mode decode shows at once on `drive_o`, in the same cycle the strobes change. The forwarding path is exposed only by the single cycle between the write ending and its commit, so the bench reads back in exactly that cycle. Aliasing and a full-depth sweep against a reference array catch address decode faults on the first wrong location read.

// File: rtl/lane_sram_pkg.sv
package lane_sram_pkg;
  typedef enum logic [1:0] {
    MODE_IDLE  = 2'd0,
    MODE_QUIET = 2'd1,
    MODE_READ  = 2'd2,
    MODE_WRITE = 2'd3
  } sram_mode_e;
endpackage

// File: rtl/lane_sram_mode_dec.sv
module lane_sram_mode_dec
  import lane_sram_pkg::*;
#(
  parameter int CS_N  = 3,
  parameter int LANES = 4
) (
  input  logic [CS_N-1:0]  cs_n_i,
  input  logic             we_n_i,
  input  logic             oe_n_i,
  input  logic [LANES-1:0] lane_n_i,
  output sram_mode_e       mode_o,
  output logic             wr_act_o,
  output logic [LANES-1:0] rd_lane_o
);
  logic sel;
  assign sel = ~|cs_n_i;

  always_comb begin
    if (!sel)                       mode_o = MODE_IDLE;
    else if (!we_n_i)               mode_o = MODE_WRITE;
    else if (!oe_n_i && !(&lane_n_i)) mode_o = MODE_READ;
    else                            mode_o = MODE_QUIET;
  end

  assign wr_act_o  = (mode_o == MODE_WRITE);
  assign rd_lane_o = (mode_o == MODE_READ) ? ~lane_n_i : '0;
endmodule

// File: rtl/lane_sram_wr_track.sv
module lane_sram_wr_track #(
  parameter int AW     = 10,
  parameter int LANES  = 4,
  parameter int LANE_W = 8,
  localparam int DW    = LANES * LANE_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_act_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic [LANES-1:0] lane_n_i,
  output logic             commit_o,
  output logic [LANES-1:0] lane_we_o,
  output logic [AW-1:0]    cap_addr_o,
  output logic [DW-1:0]    cap_data_o,
  output logic [LANES-1:0] cap_mask_o
);
  logic wr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q       <= 1'b0;
      cap_addr_o <= '0;
      cap_data_o <= '0;
      cap_mask_o <= '0;
    end else begin
      wr_q <= wr_act_i;
      if (wr_act_i) begin
        cap_addr_o <= addr_i;
        cap_data_o <= wdata_i;
        cap_mask_o <= ~lane_n_i;
      end
    end
  end

  // terminating edge: active last sample, inactive now
  assign commit_o  = wr_q & ~wr_act_i;
  assign lane_we_o = {LANES{commit_o}} & cap_mask_o;

  p_single_commit_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |=> !commit_o);
  p_commit_after_write_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |-> $past(wr_act_i));
endmodule

// File: rtl/lane_sram_array.sv
module lane_sram_array #(
  parameter int AW     = 10,
  parameter int LANES  = 4,
  parameter int LANE_W = 8,
  localparam int DEPTH = 1 << AW,
  localparam int DW    = LANES * LANE_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LANES-1:0] we_i,
  input  logic [AW-1:0]    waddr_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic [AW-1:0]    raddr_i,
  output logic [DW-1:0]    rdata_o
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk_i) begin
      if (we_i[l]) mem[waddr_i] <= wdata_i[l*LANE_W +: LANE_W];
    end

    assign rdata_o[l*LANE_W +: LANE_W] = mem[raddr_i];

    p_lane_store_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      we_i[l] |=> mem[$past(waddr_i)] == $past(wdata_i[l*LANE_W +: LANE_W]));
  end
endmodule

// File: rtl/lane_sram_model.sv
module lane_sram_model #(
  parameter int ADDR_W     = 19,
  parameter int DEPTH_LOG2 = 10,
  parameter int CS_N       = 3,
  parameter int LANES      = 4,
  parameter int LANE_W     = 8,
  localparam int DW        = LANES * LANE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CS_N-1:0]   cs_n_i,
  input  logic              we_n_i,
  input  logic              oe_n_i,
  input  logic [LANES-1:0]  lane_n_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  output logic [LANES-1:0]  drive_o
);
  import lane_sram_pkg::*;

  sram_mode_e           mode;
  logic                 wr_act;
  logic [LANES-1:0]     rd_lane;
  logic                 commit;
  logic [LANES-1:0]     lane_we;
  logic [DEPTH_LOG2-1:0] word_addr;
  logic [DEPTH_LOG2-1:0] cap_addr;
  logic [DW-1:0]        cap_data;
  logic [LANES-1:0]     cap_mask;
  logic [DW-1:0]        arr_rdata;
  logic                 fwd;

  assign word_addr = addr_i[DEPTH_LOG2-1:0];

  lane_sram_mode_dec #(.CS_N(CS_N), .LANES(LANES)) u_dec (
    .cs_n_i   (cs_n_i),
    .we_n_i   (we_n_i),
    .oe_n_i   (oe_n_i),
    .lane_n_i (lane_n_i),
    .mode_o   (mode),
    .wr_act_o (wr_act),
    .rd_lane_o(rd_lane)
  );

  lane_sram_wr_track #(.AW(DEPTH_LOG2), .LANES(LANES), .LANE_W(LANE_W)) u_trk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_act_i  (wr_act),
    .addr_i    (word_addr),
    .wdata_i   (wdata_i),
    .lane_n_i  (lane_n_i),
    .commit_o  (commit),
    .lane_we_o (lane_we),
    .cap_addr_o(cap_addr),
    .cap_data_o(cap_data),
    .cap_mask_o(cap_mask)
  );

  lane_sram_array #(.AW(DEPTH_LOG2), .LANES(LANES), .LANE_W(LANE_W)) u_arr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (lane_we),
    .waddr_i(cap_addr),
    .wdata_i(cap_data),
    .raddr_i(word_addr),
    .rdata_o(arr_rdata)
  );

  // pending commit to the word being read: forward captured lanes
  assign fwd = commit && (cap_addr == word_addr);

  for (genvar l = 0; l < LANES; l++) begin : g_out
    logic [LANE_W-1:0] lane_val;
    assign lane_val = (fwd && cap_mask[l]) ? cap_data[l*LANE_W +: LANE_W]
                                           : arr_rdata[l*LANE_W +: LANE_W];
    assign rdata_o[l*LANE_W +: LANE_W] = rd_lane[l] ? lane_val : '0;
  end
  assign drive_o = rd_lane;

  p_desel_float_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|cs_n_i) |-> (drive_o == '0 && rdata_o == '0));
  p_write_float_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_n_i == '0 && !we_n_i) |-> drive_o == '0);
  p_lane_gate_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drive_o & lane_n_i) == '0);
  p_oe_float_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_n_i |-> drive_o == '0);
  p_mode_drive_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drive_o != '0) |-> (mode == MODE_READ));
endmodule

// File: tb/sim_lane_sram_model.sv
`timescale 1ns/1ps
module sim_lane_sram_model;
  localparam int AW    = 10;
  localparam int DEPTH = 1 << AW;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [18:0] addr = '0;
  logic [2:0]  cs_n = 3'b111;
  logic        we_n = 1'b1;
  logic        oe_n = 1'b1;
  logic [3:0]  lane_n = 4'hF;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [3:0]  drive;

  int total = 0;
  int bad = 0;
  bit done = 0;
  logic [31:0] ref_mem [DEPTH];

  always #4 clk = ~clk;

  lane_sram_model u0 (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .cs_n_i(cs_n), .we_n_i(we_n),
    .oe_n_i(oe_n), .lane_n_i(lane_n), .wdata_i(wdata), .rdata_o(rdata), .drive_o(drive)
  );

  // {op, addr, lane_n, data, exp_drive, exp_data}; op 1 = write
  localparam logic [91:0] VEC [8] = '{
    {1'b1, 19'h00005, 4'b0000, 32'hA1B2C3D4, 4'h0, 32'h0},
    {1'b0, 19'h00005, 4'b0000, 32'h0,        4'hF, 32'hA1B2C3D4},
    {1'b1, 19'h00005, 4'b1110, 32'h000000EE, 4'h0, 32'h0},
    {1'b0, 19'h00005, 4'b0000, 32'h0,        4'hF, 32'hA1B2C3EE},
    {1'b1, 19'h00005, 4'b0111, 32'h55000000, 4'h0, 32'h0},
    {1'b0, 19'h00005, 4'b1010, 32'h0,        4'h5, 32'h00B200EE},
    {1'b0, 19'h00405, 4'b0000, 32'h0,        4'hF, 32'h55B2C3EE},
    {1'b0, 19'h00005, 4'b1111, 32'h0,        4'h0, 32'h0}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic go_idle();
    cs_n = 3'b111; we_n = 1'b1; oe_n = 1'b1; lane_n = 4'hF;
  endtask

  task automatic do_write(input logic [18:0] a, input logic [31:0] d, input logic [3:0] ln);
    @(negedge clk);
    addr = a; wdata = d; lane_n = ln; cs_n = 3'b000; we_n = 1'b0; oe_n = 1'b0;
    #1 chk("R2 no drive while writing", {28'd0, drive}, 32'd0);
    @(negedge clk);
    go_idle();
    @(negedge clk);
  endtask

  task automatic do_read(input string tag, input logic [18:0] a, input logic [3:0] ln,
                         input logic [3:0] exp_drv, input logic [31:0] exp_dat);
    @(negedge clk);
    addr = a; lane_n = ln; cs_n = 3'b000; we_n = 1'b1; oe_n = 1'b0;
    #1;
    chk({tag, " drive"}, {28'd0, drive}, {28'd0, exp_drv});
    chk({tag, " data"}, rdata, exp_dat);
  endtask

  function automatic logic [31:0] pat(input int i);
    return (i * 32'h01000193) ^ 32'h5A5A0F0F;
  endfunction

  function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] nw,
                                        input logic [3:0] ln);
    logic [31:0] r = old;
    for (int k = 0; k < 4; k++) if (!ln[k]) r[k*8 +: 8] = nw[k*8 +: 8];
    return r;
  endfunction

  initial begin
    #(8 * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // reset state, R1 / R10
    repeat (3) @(negedge clk);
    #1;
    chk("R1 reset no drive", {28'd0, drive}, 32'd0);
    chk("R1 reset rdata zero", rdata, 32'd0);
    @(negedge clk) rst_n = 1'b1;

    // vector table: R3 R5 R6 R7 R8
    for (int v = 0; v < 8; v++) begin
      if (VEC[v][91])
        do_write(VEC[v][90:72], VEC[v][67:36], VEC[v][71:68]);
      else
        do_read($sformatf("R6 vec%0d", v), VEC[v][90:72], VEC[v][71:68],
                VEC[v][35:32], VEC[v][31:0]);
    end
    @(negedge clk) go_idle();

    // full sweep: R4
    for (int i = 0; i < DEPTH; i++) begin
      do_write(19'(i), pat(i), 4'b0000);
      ref_mem[i] = pat(i);
    end
    for (int i = 0; i < DEPTH; i++)
      do_read("R4 sweep", 19'(i), 4'b0000, 4'hF, ref_mem[i]);
    @(negedge clk) go_idle();

    // deselect by each chip select alone: R1
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      addr = 19'd7; wdata = 32'hFFFFFFFF; lane_n = 4'h0;
      cs_n = 3'(1 << k); we_n = 1'b0; oe_n = 1'b0;
      #1;
      chk("R1 deselect drive", {28'd0, drive}, 32'd0);
      chk("R1 deselect rdata", rdata, 32'd0);
      @(negedge clk) go_idle();
      @(negedge clk);
    end
    do_read("R1 no write while deselected", 19'd7, 4'h0, 4'hF, ref_mem[7]);

    // selected, OE high: R7
    @(negedge clk);
    addr = 19'd3; cs_n = 3'b000; we_n = 1'b1; oe_n = 1'b1; lane_n = 4'h0;
    #1 chk("R7 oe high no drive", {28'd0, drive}, 32'd0);

    // upper address bits ignored on write: R8
    do_write(19'h7FC08, 32'hCAFEF00D, 4'b0000);
    ref_mem[8] = 32'hCAFEF00D;
    do_read("R8 alias write", 19'd8, 4'h0, 4'hF, ref_mem[8]);

    // forwarding in the cycle before commit: R9
    @(negedge clk);
    addr = 19'd9; wdata = 32'h13572468; lane_n = 4'b1001;
    cs_n = 3'b000; we_n = 1'b0; oe_n = 1'b0;
    @(negedge clk);
    we_n = 1'b1; lane_n = 4'b0000;
    ref_mem[9] = merge(ref_mem[9], 32'h13572468, 4'b1001);
    #1 chk("R9 forwarded read", rdata, ref_mem[9]);
    @(negedge clk);
    #1 chk("R9 read after commit", rdata, ref_mem[9]);
    @(negedge clk) go_idle();

    // last sampled data and lanes win: R4
    @(negedge clk);
    addr = 19'd12; wdata = 32'h11111111; lane_n = 4'b0000;
    cs_n = 3'b000; we_n = 1'b0; oe_n = 1'b1;
    @(negedge clk);
    wdata = 32'h2222BEEF; lane_n = 4'b1100;
    @(negedge clk) go_idle();
    @(negedge clk);
    ref_mem[12] = merge(ref_mem[12], 32'h2222BEEF, 4'b1100);
    do_read("R4 last sample stored", 19'd12, 4'h0, 4'hF, ref_mem[12]);

    // write ended during reset is dropped: R10
    @(negedge clk);
    addr = 19'd20; wdata = 32'hDEADDEAD; lane_n = 4'h0;
    cs_n = 3'b000; we_n = 1'b0; oe_n = 1'b1;
    @(negedge clk) rst_n = 1'b0;
    @(negedge clk) go_idle();
    @(negedge clk) rst_n = 1'b1;
    do_read("R10 write discarded by reset", 19'd20, 4'h0, 4'hF, ref_mem[20]);

    // single lane readback: R3
    do_read("R3 lane 3 only", 19'd20, 4'b0111, 4'b1000, {ref_mem[20][31:24], 24'd0});
    @(negedge clk) go_idle();

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule